// File: doc/BRIEF.md
# Interrupt Redirection Controller

This block turns a set of interrupt input pins into delivery requests for processor-local interrupt controllers. Each pin has its own redirection entry. The entry holds a vector, a delivery mode, a destination mode, a destination, a pin polarity, a trigger mode and a mask. When an unmasked pin becomes active, the block presents a request that carries the entry's routing fields. It holds that request until a downstream agent accepts it.

Software sees only two 32-bit locations. An index-select register at byte offset 0x00 picks an internal register, and a data window at byte offset 0x10 reads or writes that register. Behind the window sit an ID register, a read-only version register, a read-only arbitration register and the redirection table. The table stores two 32-bit words per entry. A level-triggered source that has been accepted is blocked by its remote-acknowledge flag. It stays blocked until an end-of-interrupt carrying its vector arrives.

Top module: `irq_redirector`

## Requirements
- R1: A write to byte offset 0x00 stores bits 7:0 as the index. A read of offset 0x00 returns the index with bits 31:8 zero. A write to any offset other than 0x00 or 0x10 has no effect, and a read of such an offset returns zero. Read data appears on `bus_rdata` one clock after `bus_rd`.
- R2: Index 0x00 holds a 4-bit ID in bits 27:24, and all other bits read zero. Index 0x02 is read-only and returns that same ID in bits 27:24.
- R3: Index 0x01 is read-only. It returns the version (parameter, default 0x20) in bits 7:0 and the highest entry number (NUM_ENT-1, default 0x17) in bits 23:16.
- R4: Entry n has its low word at index 0x10+2n and its high word at index 0x11+2n. The high word keeps only bits 31:24, which hold the destination. The low word is laid out as: vector 7:0, delivery mode 10:8, destination mode 11, delivery status 12, polarity 13 (1 = active low), remote flag 14, trigger 15 (1 = level) and mask 16 (1 = masked). All other indices read zero and ignore writes.
- R5: Delivery status, the remote flag and the reserved bits cannot be written. Writing ones to them leaves them reading as their current value.
- R6: After reset, every low word reads 0x00010000, every high word reads 0, the ID and the index read 0, and no request is raised.
- R7: An edge entry latches one active edge: a rising edge with polarity 0, or a falling edge with polarity 1. That edge produces exactly one request. A pin held at its active level produces no further request.
- R8: A level entry requests while the pin is at its active level. On accept, its remote flag sets and no new request is raised. Once an end-of-interrupt clears the flag, a still-active pin requests again.
- R9: A masked entry raises no request, and an edge that arrives while the entry is masked is not remembered once the mask is removed.
- R10: A request carries the vector, the delivery mode, the destination mode, the destination and the entry number. All of these stay stable until a cycle with `req_accept` high. After that cycle `req_valid` is low for at least one cycle.
- R11: When several entries are waiting, the lowest entry number is served first.
- R12: Delivery status reads 1 from the moment an entry is waiting until its request is accepted, and reads 0 otherwise.
- R13: An end-of-interrupt clears the remote flag of every level entry whose vector matches it. It leaves entries with other vectors unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W (5) | Byte offset: 0x00 index, 0x10 window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| irq_pins | input | NUM_ENT (24) | Interrupt input pins, synchronous to clk |
| req_valid | output | 1 | Delivery request pending |
| req_vector | output | 8 | Vector of the request |
| req_dmode | output | 3 | Delivery mode of the request |
| req_dstmode | output | 1 | Destination mode (0 physical, 1 logical) |
| req_dest | output | 8 | Destination of the request |
| req_entry | output | IDX_W (5) | Entry number of the request |
| req_accept | input | 1 | Accepts the current request |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_vector | input | 8 | Vector being acknowledged |

## Verification
The bench targets the following corner cases, each paired with the failure a wrong design would show:
- A pin held active after its edge was served: a design that confuses level with edge would deliver it again.
- A level source left asserted across an end-of-interrupt with a non-matching vector and then a matching one: a design with a broken remote flag would either redeliver too early or never.
- An edge pulse while the entry is masked, followed by unmasking: a design that latches under mask would deliver a stale interrupt.
- Simultaneous edges on two entries: the order exposes a reversed priority.
- A request that is held without accept: it must keep its fields stable and show a set delivery status.
- Active-low sources of both kinds: they expose a polarity that is applied only to one trigger mode.
- Writes of all ones into read-only and reserved bits: a decode that forgets to mask them would show up on read-back.

// File: rtl/irq_redir_pkg.sv
package irq_redir_pkg;
  localparam int unsigned VEC_W  = 8;
  localparam int unsigned DEST_W = 8;
  localparam int unsigned DM_W   = 3;

  // low-word bit positions (software visible layout)
  localparam int unsigned B_DMODE = 8;
  localparam int unsigned B_DSTM  = 11;
  localparam int unsigned B_DSTAT = 12;
  localparam int unsigned B_POL   = 13;
  localparam int unsigned B_RIRR  = 14;
  localparam int unsigned B_TRIG  = 15;
  localparam int unsigned B_MASK  = 16;

  typedef struct packed {
    logic              mask;
    logic              trig;
    logic              pol;
    logic              dstm;
    logic [DM_W-1:0]   dmode;
    logic [VEC_W-1:0]  vec;
    logic [DEST_W-1:0] dest;
  } rte_t;

  localparam rte_t RTE_RESET = '{mask: 1'b1, default: '0};
endpackage

// File: rtl/irq_redir_src.sv
module irq_redir_src (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  input  logic pol,
  input  logic trig,
  input  logic mask,
  input  logic rirr,
  input  logic clr,
  output logic want
);
  logic pin_q, pin_d, pend_q;
  logic edge_hit;

  assign edge_hit = pol ? (pin_d & ~pin_q) : (pin_q & ~pin_d);

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_q  <= 1'b0;
      pin_d  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      pin_q <= pin;
      pin_d <= pin_q;
      if (mask || trig)  pend_q <= 1'b0;
      else if (edge_hit) pend_q <= 1'b1;
      else if (clr)      pend_q <= 1'b0;
    end
  end

  assign want = ~mask & (trig ? ((pin_q ^ pol) & ~rirr) : pend_q);
endmodule

// File: rtl/irq_redir_pick.sv
module irq_redir_pick #(
  parameter int unsigned N  = 24,
  parameter int unsigned IW = 5
) (
  input  logic [N-1:0]  want,
  output logic          hit,
  output logic [IW-1:0] idx
);
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (want[i]) begin
        hit = 1'b1;
        idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/irq_redirector.sv
module irq_redirector
  import irq_redir_pkg::*;
#(
  parameter int unsigned NUM_ENT = 24,
  parameter logic [7:0]  VERSION = 8'h20,
  parameter int unsigned ADDR_W  = 5,
  localparam int unsigned IDX_W  = $clog2(NUM_ENT)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NUM_ENT-1:0] irq_pins,
  output logic              req_valid,
  output logic [7:0]        req_vector,
  output logic [2:0]        req_dmode,
  output logic              req_dstmode,
  output logic [7:0]        req_dest,
  output logic [IDX_W-1:0]  req_entry,
  input  logic              req_accept,
  input  logic              eoi_valid,
  input  logic [7:0]        eoi_vector
);
  localparam logic [ADDR_W-1:0] SEL_OFS = '0;
  localparam logic [ADDR_W-1:0] WIN_OFS = ADDR_W'(16);
  localparam logic [7:0] IX_ID  = 8'h00;
  localparam logic [7:0] IX_VER = 8'h01;
  localparam logic [7:0] IX_ARB = 8'h02;
  localparam logic [7:0] TBL_LO = 8'h10;
  localparam logic [7:0] TBL_HI = 8'(16 + 2 * NUM_ENT);
  localparam logic [7:0] MAX_ENT = 8'(NUM_ENT - 1);

  logic [7:0] sel_q;
  logic [3:0] id_q;
  rte_t       tbl_q [NUM_ENT];
  logic [NUM_ENT-1:0] rirr_q;
  logic [NUM_ENT-1:0] want_v, mask_v, trig_v, clr_v;

  // ---------------- index decode ----------------
  logic             in_tbl, hi_word;
  logic [7:0]       off;
  logic [IDX_W-1:0] ent;
  logic             wr_sel, wr_win, acc;

  assign off     = sel_q - TBL_LO;
  assign in_tbl  = (sel_q >= TBL_LO) && (sel_q < TBL_HI);
  assign hi_word = off[0];
  assign ent     = off[IDX_W:1];
  assign wr_sel  = bus_wr && (bus_addr == SEL_OFS);
  assign wr_win  = bus_wr && (bus_addr == WIN_OFS);
  assign acc     = req_valid && req_accept;

  logic unused_bits;
  assign unused_bits = ^{bus_wdata[23:17], bus_wdata[14], bus_wdata[12], off[7:IDX_W+1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= '0;
      id_q  <= '0;
    end else begin
      if (wr_sel) sel_q <= bus_wdata[7:0];
      if (wr_win && sel_q == IX_ID) id_q <= bus_wdata[27:24];
    end
  end

  // ---------------- redirection table ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_ENT; i++) tbl_q[i] <= RTE_RESET;
    end else if (wr_win && in_tbl) begin
      if (hi_word) begin
        tbl_q[ent].dest <= bus_wdata[31:24];
      end else begin
        tbl_q[ent].vec   <= bus_wdata[7:0];
        tbl_q[ent].dmode <= bus_wdata[B_DMODE +: DM_W];
        tbl_q[ent].dstm  <= bus_wdata[B_DSTM];
        tbl_q[ent].pol   <= bus_wdata[B_POL];
        tbl_q[ent].trig  <= bus_wdata[B_TRIG];
        tbl_q[ent].mask  <= bus_wdata[B_MASK];
      end
    end
  end

  // ---------------- per-entry sources ----------------
  for (genvar g = 0; g < NUM_ENT; g++) begin : g_src
    assign mask_v[g] = tbl_q[g].mask;
    assign trig_v[g] = tbl_q[g].trig;
    assign clr_v[g]  = acc && (req_entry == IDX_W'(g));

    irq_redir_src u_src (
      .clk  (clk),
      .rst  (rst),
      .pin  (irq_pins[g]),
      .pol  (tbl_q[g].pol),
      .trig (tbl_q[g].trig),
      .mask (tbl_q[g].mask),
      .rirr (rirr_q[g]),
      .clr  (clr_v[g]),
      .want (want_v[g])
    );

    always_ff @(posedge clk) begin
      if (rst) begin
        rirr_q[g] <= 1'b0;
      end else if (clr_v[g] && tbl_q[g].trig) begin
        rirr_q[g] <= 1'b1;
      end else if (eoi_valid && tbl_q[g].trig && tbl_q[g].vec == eoi_vector) begin
        rirr_q[g] <= 1'b0;
      end
    end
  end

  // ---------------- request selection ----------------
  logic             pick_hit;
  logic [IDX_W-1:0] pick_idx;

  irq_redir_pick #(.N(NUM_ENT), .IW(IDX_W)) u_pick (
    .want (want_v),
    .hit  (pick_hit),
    .idx  (pick_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      req_valid   <= 1'b0;
      req_vector  <= '0;
      req_dmode   <= '0;
      req_dstmode <= 1'b0;
      req_dest    <= '0;
      req_entry   <= '0;
    end else if (acc) begin
      req_valid <= 1'b0;
    end else if (!req_valid && pick_hit) begin
      req_valid   <= 1'b1;
      req_vector  <= tbl_q[pick_idx].vec;
      req_dmode   <= tbl_q[pick_idx].dmode;
      req_dstmode <= tbl_q[pick_idx].dstm;
      req_dest    <= tbl_q[pick_idx].dest;
      req_entry   <= pick_idx;
    end
  end

  // ---------------- read path ----------------
  logic [31:0] win_word, rd_word;

  always_comb begin
    win_word = '0;
    if (sel_q == IX_ID || sel_q == IX_ARB) begin
      win_word[27:24] = id_q;
    end else if (sel_q == IX_VER) begin
      win_word[7:0]   = VERSION;
      win_word[23:16] = MAX_ENT;
    end else if (in_tbl) begin
      if (hi_word) begin
        win_word[31:24] = tbl_q[ent].dest;
      end else begin
        win_word[7:0]              = tbl_q[ent].vec;
        win_word[B_DMODE +: DM_W]  = tbl_q[ent].dmode;
        win_word[B_DSTM]           = tbl_q[ent].dstm;
        win_word[B_DSTAT]          = want_v[ent];
        win_word[B_POL]            = tbl_q[ent].pol;
        win_word[B_RIRR]           = rirr_q[ent];
        win_word[B_TRIG]           = tbl_q[ent].trig;
        win_word[B_MASK]           = tbl_q[ent].mask;
      end
    end
  end

  always_comb begin
    rd_word = '0;
    if (bus_addr == SEL_OFS)      rd_word = {24'h0, sel_q};
    else if (bus_addr == WIN_OFS) rd_word = win_word;
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_word;
  end
endmodule

// File: rtl/irq_redir_chk.sv
module irq_redir_chk #(
  parameter int unsigned NUM_ENT = 24,
  parameter int unsigned IDX_W   = 5
) (
  input logic               clk,
  input logic               rst,
  input logic               req_valid,
  input logic               req_accept,
  input logic [7:0]         req_vector,
  input logic [IDX_W-1:0]   req_entry,
  input logic [NUM_ENT-1:0] want_v,
  input logic [NUM_ENT-1:0] mask_v,
  input logic [NUM_ENT-1:0] trig_v,
  input logic [NUM_ENT-1:0] rirr_v
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    req_valid && !req_accept |=> req_valid && $stable(req_vector) && $stable(req_entry)); // R10
  AST_REQ_GAP: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_accept |=> !req_valid); // R10
  AST_ENTRY_RANGE: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> (32'(req_entry) < NUM_ENT)); // R10
  AST_MASK_QUIET: assert property (@(posedge clk) disable iff (rst)
    (want_v & mask_v) == '0); // R9
  AST_RIRR_BLOCK: assert property (@(posedge clk) disable iff (rst)
    (want_v & trig_v & rirr_v) == '0); // R8
endmodule

bind irq_redirector irq_redir_chk #(.NUM_ENT(NUM_ENT), .IDX_W(IDX_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .req_accept (req_accept),
  .req_vector (req_vector),
  .req_entry  (req_entry),
  .want_v     (want_v),
  .mask_v     (mask_v),
  .trig_v     (trig_v),
  .rirr_v     (rirr_q)
);

// File: tb/irq_redirector_tb_top.sv
module irq_redirector_tb_top;
  localparam int NE = 24;
  localparam int IW = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [4:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [NE-1:0] irq_pins = '0;
  logic req_valid, req_dstmode, req_accept = 1'b0;
  logic [7:0] req_vector, req_dest;
  logic [2:0] req_dmode;
  logic [IW-1:0] req_entry;
  logic eoi_valid = 1'b0;
  logic [7:0] eoi_vector = '0;

  always #5 clk = ~clk;

  irq_redirector dut_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_pins(irq_pins),
    .req_valid(req_valid), .req_vector(req_vector), .req_dmode(req_dmode),
    .req_dstmode(req_dstmode), .req_dest(req_dest), .req_entry(req_entry),
    .req_accept(req_accept), .eoi_valid(eoi_valid), .eoi_vector(eoi_vector)
  );

  typedef struct packed {
    logic [IW-1:0] ent;
    logic [7:0]    vec;
    logic [2:0]    dm;
    logic          dstm;
    logic [7:0]    dest;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk = 0, n_err = 0;
  bit   mon_en = 1'b1;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic push(input int e, input logic [7:0] v, input logic [2:0] dm, input logic dm2, input logic [7:0] d);
    exp_t x;
    x.ent = IW'(e); x.vec = v; x.dm = dm; x.dstm = dm2; x.dest = d;
    exp_q.push_back(x);
  endtask

  // monitor: compare each request against the scoreboard and accept it
  initial begin
    forever begin
      @(negedge clk);
      if (req_accept) begin
        req_accept = 1'b0;
      end else if (mon_en && req_valid && !rst) begin
        exp_t a;
        a = '{ent: req_entry, vec: req_vector, dm: req_dmode, dstm: req_dstmode, dest: req_dest};
        if (exp_q.size() == 0) begin
          chk(1'b0, "R7/R8/R9 unexpected request", 32'(a), 32'h0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(a == e, "R10 request fields", 32'(a), 32'(e));
        end
        req_accept = 1'b1;
      end
    end
  end

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic win_wr(input logic [7:0] ix, input logic [31:0] d);
    wr(5'h00, {24'h0, ix});
    wr(5'h10, d);
  endtask

  task automatic win_chk(input logic [7:0] ix, input logic [31:0] exp, input string tag);
    logic [31:0] d;
    wr(5'h00, {24'h0, ix});
    rd(5'h10, d);
    chk(d == exp, tag, d, exp);
  endtask

  task automatic drain(input string tag);
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (exp_q.size() == 0 && !req_valid && !req_accept) break;
    end
    chk(exp_q.size() == 0, tag, 32'(exp_q.size()), 32'h0);
  endtask

  task automatic quiet(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic eoi(input logic [7:0] v);
    @(negedge clk); eoi_valid = 1'b1; eoi_vector = v;
    @(negedge clk); eoi_valid = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog act=0 exp=1");
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // reset state R6, version R3
    chk(req_valid == 1'b0, "R6 no request after reset", 32'(req_valid), 0);
    rd(5'h00, d);               chk(d == 0, "R6 index reset", d, 0);
    win_chk(8'h00, 32'h0, "R6 ID reset");
    win_chk(8'h01, 32'h0017_0020, "R3 version word");
    win_chk(8'h10, 32'h0001_0000, "R6 entry0 low reset");
    win_chk(8'h3F, 32'h0, "R6 entry23 high reset");
    win_chk(8'h05, 32'h0, "R4 undefined index");

    // R1 index register and stray offsets
    wr(5'h00, 32'hABCD_1234);
    rd(5'h00, d);               chk(d == 32'h34, "R1 index readback", d, 32'h34);
    wr(5'h04, 32'hFFFF_FFFF);
    rd(5'h00, d);               chk(d == 32'h34, "R1 stray write ignored", d, 32'h34);
    rd(5'h08, d);               chk(d == 0, "R1 stray offset reads zero", d, 0);

    // R2 ID and arbitration, R3 read-only version
    win_wr(8'h00, 32'hFFFF_FFFF);
    win_chk(8'h00, 32'h0F00_0000, "R2 ID write");
    win_chk(8'h02, 32'h0F00_0000, "R2 arbitration follows ID");
    win_wr(8'h02, 32'h0);
    win_chk(8'h02, 32'h0F00_0000, "R2 arbitration read-only");
    win_wr(8'h01, 32'h0);
    win_chk(8'h01, 32'h0017_0020, "R3 version read-only");

    // R4/R5 field layout and read-only bits on entry 5
    win_wr(8'h1A, 32'hFFFF_FFFF);
    win_chk(8'h1A, 32'h0001_AFFF, "R5 entry5 low read-only bits");
    win_wr(8'h1B, 32'hFFFF_FFFF);
    win_chk(8'h1B, 32'hFF00_0000, "R4 entry5 high word");
    win_wr(8'h1A, 32'h0001_0000);
    win_wr(8'h40, 32'hFFFF_FFFF);
    win_chk(8'h40, 32'h0, "R4 index past table");

    // R7 rising edge, entry 3
    win_wr(8'h17, 32'h4200_0000);
    win_wr(8'h16, 32'h0000_0831);
    push(3, 8'h31, 3'd0, 1'b1, 8'h42);
    @(negedge clk); irq_pins[3] = 1'b1;
    drain("R7 edge delivered");
    quiet(20);
    chk(req_valid == 0 && exp_q.size() == 0, "R7 held pin no redelivery", 32'(req_valid), 0);
    @(negedge clk); irq_pins[3] = 1'b0;

    // R7 falling edge, entry 4, active low, NMI mode
    @(negedge clk); irq_pins[4] = 1'b1;
    win_wr(8'h19, 32'h4400_0000);
    win_wr(8'h18, 32'h0000_2444);
    quiet(10);
    chk(req_valid == 0, "R7 idle active-low pin quiet", 32'(req_valid), 0);
    push(4, 8'h44, 3'd4, 1'b0, 8'h44);
    @(negedge clk); irq_pins[4] = 1'b0;
    drain("R7 falling edge delivered");
    @(negedge clk); irq_pins[4] = 1'b1;
    quiet(20);
    chk(req_valid == 0, "R7 inactive edge ignored", 32'(req_valid), 0);

    // R10/R12 request held without accept
    mon_en = 1'b0;
    @(negedge clk); irq_pins[3] = 1'b1;
    @(negedge clk); irq_pins[3] = 1'b0;
    quiet(8);
    chk(req_valid && req_vector == 8'h31 && req_entry == 3, "R10 request raised", {req_valid, 23'h0, req_vector}, 32'h8000_0031);
    quiet(6);
    chk(req_valid && req_vector == 8'h31 && req_dest == 8'h42, "R10 request held stable", {req_valid, 23'h0, req_vector}, 32'h8000_0031);
    win_chk(8'h16, 32'h0000_1831, "R12 status set while waiting");
    push(3, 8'h31, 3'd0, 1'b1, 8'h42);
    mon_en = 1'b1;
    drain("R10 held request accepted");
    win_chk(8'h16, 32'h0000_0831, "R12 status clear after accept");

    // R9 mask drops edges
    win_wr(8'h16, 32'h0001_0831);
    @(negedge clk); irq_pins[3] = 1'b1;
    @(negedge clk); irq_pins[3] = 1'b0;
    quiet(5);
    win_wr(8'h16, 32'h0000_0831);
    quiet(20);
    chk(req_valid == 0 && exp_q.size() == 0, "R9 masked edge lost", 32'(req_valid), 0);

    // R11 priority: entries 2 and 7 together
    win_wr(8'h14, 32'h0000_0020);
    win_wr(8'h1E, 32'h0000_0070);
    mon_en = 1'b0;
    @(negedge clk); irq_pins[2] = 1'b1; irq_pins[7] = 1'b1;
    quiet(6);
    chk(req_valid && req_entry == 2, "R11 lowest entry first", 32'(req_entry), 2);
    push(2, 8'h20, 3'd0, 1'b0, 8'h00);
    push(7, 8'h70, 3'd0, 1'b0, 8'h00);
    mon_en = 1'b1;
    drain("R11 both served in order");
    @(negedge clk); irq_pins[2] = 1'b0; irq_pins[7] = 1'b0;

    // R8/R13 level entries 9 and 10 sharing vector 0x90
    win_wr(8'h23, 32'h0900_0000);
    win_wr(8'h22, 32'h0000_8090);
    win_wr(8'h25, 32'h0A00_0000);
    win_wr(8'h24, 32'h0000_8090);
    push(9, 8'h90, 3'd0, 1'b0, 8'h09);
    push(10, 8'h90, 3'd0, 1'b0, 8'h0A);
    @(negedge clk); irq_pins[9] = 1'b1; irq_pins[10] = 1'b1;
    drain("R8 level delivered");
    quiet(20);
    chk(req_valid == 0 && exp_q.size() == 0, "R8 remote flag blocks", 32'(req_valid), 0);
    win_chk(8'h22, 32'h0000_C090, "R8 remote flag set entry9");
    win_chk(8'h24, 32'h0000_C090, "R8 remote flag set entry10");
    eoi(8'h91);
    quiet(10);
    win_chk(8'h22, 32'h0000_C090, "R13 other vector leaves flag");
    push(9, 8'h90, 3'd0, 1'b0, 8'h09);
    push(10, 8'h90, 3'd0, 1'b0, 8'h0A);
    eoi(8'h90);
    drain("R8 redelivery after EOI");
    @(negedge clk); irq_pins[9] = 1'b0; irq_pins[10] = 1'b0;
    eoi(8'h90);
    quiet(5);
    win_chk(8'h22, 32'h0000_8090, "R13 flag cleared entry9");
    win_chk(8'h24, 32'h0000_8090, "R13 flag cleared entry10");

    // R8 active-low level, entry 12
    @(negedge clk); irq_pins[12] = 1'b1;
    win_wr(8'h28, 32'h0000_A0A0);
    quiet(20);
    chk(req_valid == 0, "R8 inactive low-level quiet", 32'(req_valid), 0);
    push(12, 8'hA0, 3'd0, 1'b0, 8'h00);
    @(negedge clk); irq_pins[12] = 1'b0;
    drain("R8 active-low level delivered");
    win_chk(8'h28, 32'h0000_E0A0, "R8 remote flag active-low");
    @(negedge clk); irq_pins[12] = 1'b1;
    eoi(8'hA0);
    quiet(20);
    chk(req_valid == 0 && exp_q.size() == 0, "R8 no redelivery when idle", 32'(req_valid), 0);
    win_chk(8'h28, 32'h0000_A0A0, "R13 active-low flag cleared");

    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule